// File: doc/BRIEF.md
# Timing-Slave Pixel Input Receiver

This block is the front end of a video encoder that supplies the pixel clock while an external graphics controller supplies the timing. The controller returns the clock with its data aligned to it. It drives three active-low strobes: line sync, frame sync and blanking. It also drives a pixel bus that carries one byte on each clock edge in multiplexed mode, or a full 24-bit word on each rising edge in parallel RGB mode. The block captures the bus on both edges, moves the strobes into the rising-edge domain, finds their leading edges and builds 24-bit pixels. Each pixel leaves the block with its horizontal index and the current line number.

Controllers that work on character clocks can place the start of active video up to a whole character (8 or 9 pixel clocks) away from where a fixed count after line sync would put it. For that reason the first active pixel of a line is normally taken from the end of blanking. When a configuration bit clears blank-based alignment, the block opens an active window instead. The window starts at a programmed number of cycles after the line-sync leading edge and lasts for a programmed number of cycles, and the blanking input is then ignored.

Top module: `timing_slave_rx`

## Requirements
- R1: A synchronous active-low reset clears pixelValid, startOfLine, startOfFrame, pixelOut, pixCount and lineCount to zero and resets the byte phase.
- R2: A strobe value sampled at rising edge k affects the outputs registered at rising edge k+2. A line-sync leading edge (hsyncN sampled 1 then 0 on consecutive rising edges) gives a one-cycle startOfLine pulse.
- R3: A frame-sync leading edge gives a one-cycle startOfFrame pulse and clears lineCount to 0. This takes priority over a line-sync edge in the same cycle.
- R4: Each line-sync leading edge without a frame-sync edge increments lineCount by one, wrapping modulo 2^LINE_W.
- R5: With cfgUseBlank=1, a cycle is active when blankN is sampled 1. The first active cycle after blankN was sampled 0 is the first active pixel, whatever its distance from line sync.
- R6: In multiplexed mode (cfgInMode other than 4'b0111), each active cycle contributes the byte on pixIn[7:0] at its rising edge and then the byte at the following falling edge. Three consecutive bytes form one pixel with R in pixelOut[23:16], G in [15:8] and B in [7:0].
- R7: With cfgInMode=4'b0111, each active cycle yields one pixel equal to pixIn[23:0] sampled at the rising edge. Falling-edge data has no effect.
- R8: pixelValid is high for one cycle per completed pixel, and only for pixels whose bytes were all taken in active cycles.
- R9: pixCount shows the index of the presented pixel within its line. It restarts at 0 for the first pixel after a first active pixel, and holds between pixels.
- R10: With cfgUseBlank=0, blankN has no effect. Counting the cycle of the line-sync leading edge as 0, cycles cfgStartOffset to cfgStartOffset+cfgActiveLen-1 are active, and cycle cfgStartOffset is the first active pixel. Nothing is active before the first line sync after reset.
- R11: The byte phase returns to R at every first active pixel, so leftover bytes from the end of a line never merge into the next line's first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Returned pixel clock; both edges carry data |
| rstN | input | 1 | Synchronous active-low reset |
| cfgUseBlank | input | 1 | 1: align to end of blanking; 0: use the programmed offset window |
| cfgInMode | input | 4 | Input format; 4'b0111 selects 24-bit parallel RGB |
| cfgStartOffset | input | OFF_W | Cycles from line-sync edge to first active cycle (offset mode) |
| cfgActiveLen | input | OFF_W | Number of active cycles per line (offset mode) |
| hsyncN | input | 1 | Active-low line sync from the controller |
| vsyncN | input | 1 | Active-low frame sync from the controller |
| blankN | input | 1 | Active-low blanking from the controller |
| pixIn | input | BYTE_W*COLORS | Pixel bus; low byte used on both edges in multiplexed mode |
| pixelOut | output | BYTE_W*COLORS | Assembled pixel, R in the top byte |
| pixelValid | output | 1 | One-cycle pulse per assembled pixel |
| startOfLine | output | 1 | One-cycle pulse on a line-sync leading edge |
| startOfFrame | output | 1 | One-cycle pulse on a frame-sync leading edge |
| pixCount | output | CNT_W | Index of the presented pixel within its line |
| lineCount | output | LINE_W | Line number within the frame |

## Verification
The bench varies the distance from line sync to the end of blanking between 8 and 9 cycles. A design that counted from line sync would then shift the pixel grid by a byte and report wrong colours. Active runs whose byte count is not a multiple of three leave stray bytes at the end of a line. A design that kept its byte phase across lines would build the next line's first pixel from those stray bytes. In offset mode, blankN toggles randomly while the window opens at offsets of zero and above. Frame and line sync fall in the same cycle, and lineCount is driven past its wrap. A design that obeyed blanking in offset mode, gave line sync priority, or overflowed the count would report a wrong pixelValid or lineCount on specific cycles.

// File: rtl/tsin_pkg.sv
`timescale 1ns/1ps
package tsin_pkg;

  // Input format code that selects full-width parallel RGB on each rising edge
  localparam logic [3:0] MODE_RGB24 = 4'b0111;

  // Controller strobes after capture, still active low
  typedef struct packed {
    logic hsN;
    logic vsN;
    logic blN;
  } strobe_t;

  // Idle strobe state: no sync, blanking asserted
  localparam strobe_t STROBE_IDLE = '{hsN: 1'b1, vsN: 1'b1, blN: 1'b0};

  // Control-to-datapath strobes for one captured cycle
  typedef struct packed {
    logic frameStart;
    logic lineStart;
    logic firstActive;
    logic active;
  } ctl_t;

endpackage

// File: rtl/tsin_capture.sv
`timescale 1ns/1ps
module tsin_capture
  import tsin_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              vsyncN,
  input  logic              blankN,
  input  logic [PIX_W-1:0]  pixIn,
  output strobe_t           strb,
  output logic [PIX_W-1:0]  riseWord,
  output logic [BYTE_W-1:0] fallByte
);

  // The falling-edge byte follows the rising-edge byte of the same cycle.
  // Stage one holds the rising-edge sample; stage two pairs it with the
  // byte caught half a cycle later.
  logic [BYTE_W-1:0] fallCap;
  strobe_t           s1Strb, s2Strb;
  logic [PIX_W-1:0]  s1Word, s2Word;
  logic [BYTE_W-1:0] s2Fall;

  always_ff @(negedge clk) begin
    fallCap <= pixIn[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Strb <= STROBE_IDLE;
      s1Word <= '0;
      s2Strb <= STROBE_IDLE;
      s2Word <= '0;
      s2Fall <= '0;
    end else begin
      s1Strb <= '{hsN: hsyncN, vsN: vsyncN, blN: blankN};
      s1Word <= pixIn;
      s2Strb <= s1Strb;
      s2Word <= s1Word;
      s2Fall <= fallCap;
    end
  end

  assign strb     = s2Strb;
  assign riseWord = s2Word;
  assign fallByte = s2Fall;

endmodule

// File: rtl/tsin_control.sv
`timescale 1ns/1ps
module tsin_control
  import tsin_pkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              cfgUseBlank,
  input  logic [OFF_W-1:0]  cfgStartOffset,
  input  logic [OFF_W-1:0]  cfgActiveLen,
  output ctl_t              ctl,
  output logic              startOfLine,
  output logic              startOfFrame,
  output logic [LINE_W-1:0] lineCount
);

  // One extra bit so offset plus length never overflows the window counter
  localparam int          CW      = OFF_W + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  strobe_t        prevStrb;
  logic           hsLead, vsLead, blEnd;
  logic [CW-1:0]  sinceHs, curCnt, startCw, lenCw;
  logic           running, winLive, winActive, winFirst;

  always_comb begin
    hsLead  = prevStrb.hsN & ~strb.hsN;
    vsLead  = prevStrb.vsN & ~strb.vsN;
    blEnd   = ~prevStrb.blN & strb.blN;
    startCw = CW'(cfgStartOffset);
    lenCw   = CW'(cfgActiveLen);
    winLive = hsLead | running;
    if (hsLead)                 curCnt = '0;
    else if (sinceHs == CNT_MAX) curCnt = CNT_MAX;
    else                        curCnt = sinceHs + 1'b1;
    winActive = winLive && (curCnt >= startCw) && ((curCnt - startCw) < lenCw);
    winFirst  = winLive && (curCnt == startCw) && (lenCw != '0);
    ctl.frameStart  = vsLead;
    ctl.lineStart   = hsLead;
    ctl.active      = cfgUseBlank ? strb.blN : winActive;
    ctl.firstActive = cfgUseBlank ? blEnd    : winFirst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStrb     <= STROBE_IDLE;
      sinceHs      <= '0;
      running      <= 1'b0;
      startOfLine  <= 1'b0;
      startOfFrame <= 1'b0;
      lineCount    <= '0;
    end else begin
      prevStrb     <= strb;
      sinceHs      <= curCnt;
      running      <= winLive;
      startOfLine  <= hsLead;
      startOfFrame <= vsLead;
      if (vsLead)      lineCount <= '0;
      else if (hsLead) lineCount <= lineCount + 1'b1;
    end
  end

  // R3
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameStart |=> (lineCount == '0) && startOfFrame);

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineStart && !ctl.frameStart) |=> (lineCount == $past(lineCount) + 1'b1));

  // R2
  line_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startOfLine |-> !$past(startOfLine));

endmodule

// File: rtl/tsin_assembler.sv
`timescale 1ns/1ps
module tsin_assembler
  import tsin_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int COLORS = 3,
  parameter int CNT_W  = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_t                       ctl,
  input  logic [3:0]                 cfgInMode,
  input  logic [BYTE_W*COLORS-1:0]   riseWord,
  input  logic [BYTE_W-1:0]          fallByte,
  output logic [BYTE_W*COLORS-1:0]   pixelOut,
  output logic                       pixelValid,
  output logic [CNT_W-1:0]           pixCount
);

  localparam int PIX_W = BYTE_W * COLORS;
  localparam int ACC_W = PIX_W - BYTE_W;
  localparam int LANES = 2;                 // rising then falling byte
  localparam int PH_W  = $clog2(COLORS);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(COLORS - 1);

  logic [PH_W-1:0]   phase, ph;
  logic [ACC_W-1:0]  partial, acc;
  logic [BYTE_W-1:0] lanes [LANES];
  logic [PIX_W-1:0]  muxPix, nextPix;
  logic              parMode, emit, nextValid;
  logic [CNT_W-1:0]  nextIdx, idxBase;

  always_comb begin
    parMode  = (cfgInMode == MODE_RGB24);
    lanes[0] = riseWord[BYTE_W-1:0];
    lanes[1] = fallByte;
    ph       = ctl.firstActive ? '0 : phase;
    acc      = partial;
    emit     = 1'b0;
    muxPix   = '0;
    if (ctl.active && !parMode) begin
      for (int i = 0; i < LANES; i++) begin
        if (ph == LAST_PH) begin
          muxPix = {acc, lanes[i]};
          emit   = 1'b1;
          ph     = '0;
        end else begin
          acc = (acc << BYTE_W) | ACC_W'(lanes[i]);
          ph  = ph + 1'b1;
        end
      end
    end
    nextValid = ctl.active & (parMode | emit);
    nextPix   = parMode ? riseWord : muxPix;
    idxBase   = ctl.firstActive ? '0 : nextIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= '0;
      partial    <= '0;
      nextIdx    <= '0;
      pixCount   <= '0;
      pixelOut   <= '0;
      pixelValid <= 1'b0;
    end else begin
      phase      <= ph;
      partial    <= acc;
      pixelValid <= nextValid;
      if (nextValid) begin
        pixelOut <= nextPix;
        pixCount <= idxBase;
        nextIdx  <= idxBase + 1'b1;
      end else begin
        nextIdx  <= idxBase;
      end
    end
  end

  // R8
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |=> !pixelValid);

  // R6
  mux_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!parMode && pixelValid && $past(pixelValid)) |=> !pixelValid);

  // R9
  par_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && ctl.firstActive) |=> (pixelValid && pixCount == '0));

endmodule

// File: rtl/timing_slave_rx.sv
`timescale 1ns/1ps
module timing_slave_rx
  import tsin_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int COLORS = 3,
  parameter int OFF_W  = 10,
  parameter int CNT_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgUseBlank,
  input  logic [3:0]               cfgInMode,
  input  logic [OFF_W-1:0]         cfgStartOffset,
  input  logic [OFF_W-1:0]         cfgActiveLen,
  input  logic                     hsyncN,
  input  logic                     vsyncN,
  input  logic                     blankN,
  input  logic [BYTE_W*COLORS-1:0] pixIn,
  output logic [BYTE_W*COLORS-1:0] pixelOut,
  output logic                     pixelValid,
  output logic                     startOfLine,
  output logic                     startOfFrame,
  output logic [CNT_W-1:0]         pixCount,
  output logic [LINE_W-1:0]        lineCount
);

  localparam int PIX_W = BYTE_W * COLORS;

  strobe_t           strb;
  logic [PIX_W-1:0]  riseWord;
  logic [BYTE_W-1:0] fallByte;
  ctl_t              ctl;

  tsin_capture #(.BYTE_W(BYTE_W), .PIX_W(PIX_W)) uCapture (
    .clk      (clk),
    .rstN     (rstN),
    .hsyncN   (hsyncN),
    .vsyncN   (vsyncN),
    .blankN   (blankN),
    .pixIn    (pixIn),
    .strb     (strb),
    .riseWord (riseWord),
    .fallByte (fallByte)
  );

  tsin_control #(.OFF_W(OFF_W), .LINE_W(LINE_W)) uControl (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .cfgUseBlank    (cfgUseBlank),
    .cfgStartOffset (cfgStartOffset),
    .cfgActiveLen   (cfgActiveLen),
    .ctl            (ctl),
    .startOfLine    (startOfLine),
    .startOfFrame   (startOfFrame),
    .lineCount      (lineCount)
  );

  tsin_assembler #(.BYTE_W(BYTE_W), .COLORS(COLORS), .CNT_W(CNT_W)) uAssembler (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgInMode  (cfgInMode),
    .riseWord   (riseWord),
    .fallByte   (fallByte),
    .pixelOut   (pixelOut),
    .pixelValid (pixelValid),
    .pixCount   (pixCount)
  );

endmodule

// File: tb/timing_slave_rx_test.sv
`timescale 1ns/1ps
module timing_slave_rx_test;

  localparam int BYTE_W = 8;
  localparam int COLORS = 3;
  localparam int OFF_W  = 10;
  localparam int CNT_W  = 12;
  localparam int LINE_W = 11;
  localparam int PIX_W  = BYTE_W * COLORS;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic              rstN = 1'b0;
  logic              cfgUseBlank = 1'b1;
  logic [3:0]        cfgInMode = 4'b0000;
  logic [OFF_W-1:0]  cfgStartOffset = '0;
  logic [OFF_W-1:0]  cfgActiveLen = '0;
  logic              hsyncN = 1'b1, vsyncN = 1'b1, blankN = 1'b0;
  logic [PIX_W-1:0]  pixIn = '0;
  logic [PIX_W-1:0]  pixelOut;
  logic              pixelValid, startOfLine, startOfFrame;
  logic [CNT_W-1:0]  pixCount;
  logic [LINE_W-1:0] lineCount;

  timing_slave_rx #(.BYTE_W(BYTE_W), .COLORS(COLORS), .OFF_W(OFF_W),
                    .CNT_W(CNT_W), .LINE_W(LINE_W)) uut (
    .clk(clk), .rstN(rstN), .cfgUseBlank(cfgUseBlank), .cfgInMode(cfgInMode),
    .cfgStartOffset(cfgStartOffset), .cfgActiveLen(cfgActiveLen),
    .hsyncN(hsyncN), .vsyncN(vsyncN), .blankN(blankN), .pixIn(pixIn),
    .pixelOut(pixelOut), .pixelValid(pixelValid), .startOfLine(startOfLine),
    .startOfFrame(startOfFrame), .pixCount(pixCount), .lineCount(lineCount)
  );

  typedef struct {
    bit v; int pix; bit sol; bit sof; int idx; int line;
  } exp_t;

  exp_t  expQ[$];
  int    vectors = 0;
  int    fails = 0;
  bit    finished = 0;
  bit    blankRandom = 0;
  string tag = "R1";

  // behavioural model state
  int mPrevHs, mPrevVs, mPrevBl, mPhase, mAcc, mIdx, mOutIdx, mLine, mRun, mCnt;

  task automatic resetModel();
    exp_t z;
    mPrevHs = 1; mPrevVs = 1; mPrevBl = 0; mPhase = 0; mAcc = 0;
    mIdx = 0; mOutIdx = 0; mLine = 0; mRun = 0; mCnt = 0;
    z = '{v: 0, pix: 0, sol: 0, sof: 0, idx: 0, line: 0};
    expQ.delete();
    expQ.push_back(z);
    expQ.push_back(z);
  endtask

  task automatic modelStep(input int rise, input int fall, input int hs,
                           input int vs, input int bl, output exp_t e);
    bit hsLead, vsLead, blRise, act, first, valid;
    int pix;
    int bytes [2];
    hsLead = (mPrevHs == 1 && hs == 0);
    vsLead = (mPrevVs == 1 && vs == 0);
    blRise = (mPrevBl == 0 && bl == 1);
    mPrevHs = hs; mPrevVs = vs; mPrevBl = bl;
    if (vsLead) mLine = 0;
    else if (hsLead) mLine = (mLine + 1) % (1 << LINE_W);
    if (cfgUseBlank) begin
      act = (bl == 1);
      first = blRise;
    end else begin
      if (hsLead) begin mRun = 1; mCnt = 0; end
      else if (mRun == 1) mCnt++;
      act = (mRun == 1) && mCnt >= int'(cfgStartOffset)
            && mCnt < int'(cfgStartOffset) + int'(cfgActiveLen);
      first = (mRun == 1) && mCnt == int'(cfgStartOffset) && cfgActiveLen != 0;
    end
    if (first) begin mPhase = 0; mIdx = 0; end
    valid = 0; pix = 0;
    if (act) begin
      if (cfgInMode == 4'b0111) begin
        valid = 1; pix = rise;
      end else begin
        bytes[0] = rise & 255;
        bytes[1] = fall & 255;
        for (int i = 0; i < 2; i++) begin
          if (mPhase == 2) begin
            pix = (mAcc << 8) | bytes[i]; valid = 1; mPhase = 0;
          end else begin
            mAcc = ((mAcc << 8) | bytes[i]) & 'hFFFF; mPhase++;
          end
        end
      end
    end
    if (valid) begin mOutIdx = mIdx % (1 << CNT_W); mIdx++; end
    e = '{v: valid, pix: pix, sol: hsLead, sof: vsLead, idx: mOutIdx, line: mLine};
  endtask

  task automatic failLine(input string req, input string what, input int got, input int exp);
    fails++;
    $display("FAIL %s [%s] %s got %0h exp %0h", req, tag, what, got, exp);
  endtask

  task automatic compareOut(input exp_t e);
    vectors++;
    if (pixelValid !== e.v) failLine("R8", "pixelValid", int'(pixelValid), int'(e.v));
    if (e.v && pixelOut !== e.pix[PIX_W-1:0])
      failLine((cfgInMode == 4'b0111) ? "R7" : "R6", "pixelOut", int'(pixelOut), e.pix);
    if (startOfLine !== e.sol) failLine("R2", "startOfLine", int'(startOfLine), int'(e.sol));
    if (startOfFrame !== e.sof) failLine("R3", "startOfFrame", int'(startOfFrame), int'(e.sof));
    if (pixCount !== e.idx[CNT_W-1:0]) failLine("R9", "pixCount", int'(pixCount), e.idx);
    if (lineCount !== e.line[LINE_W-1:0]) failLine("R4", "lineCount", int'(lineCount), e.line);
  endtask

  // Entered 1.25 ns before a rising edge; returns 1.25 ns before the next one.
  task automatic doCycle(input int rise, input int fall, input bit hs,
                         input bit vs, input bit bl, input bit chk);
    exp_t e, got;
    pixIn  = rise[PIX_W-1:0];
    hsyncN = hs; vsyncN = vs; blankN = bl;
    #2.5;
    pixIn[BYTE_W-1:0] = fall[BYTE_W-1:0];
    if (chk) begin
      modelStep(rise, fall, hs, vs, bl, e);
      expQ.push_back(e);
      got = expQ.pop_front();
      compareOut(got);
    end
    #2.5;
  endtask

  task automatic idle(input int n, input bit chk);
    for (int i = 0; i < n; i++) doCycle(0, 0, 1, 1, 0, chk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3, 0);
    // R1: outputs cleared by the reset edges
    tag = "R1";
    vectors++;
    if (pixelValid !== 1'b0 || startOfLine !== 1'b0 || startOfFrame !== 1'b0 ||
        pixelOut !== '0 || pixCount !== '0 || lineCount !== '0)
      failLine("R1", "reset outputs", int'({pixelValid, startOfLine, startOfFrame}) | int'(lineCount), 0);
    rstN = 1'b1;
    resetModel();
  endtask

  function automatic bit blankBit(input bit want);
    return blankRandom ? bit'($urandom % 2) : want;
  endfunction

  task automatic sendLine(input int hsLen, input int porch, input int act,
                          input int back, input bit newFrame);
    for (int i = 0; i < hsLen; i++)
      doCycle(int'($urandom), int'($urandom), 0, newFrame ? 1'b0 : 1'b1, blankBit(0), 1);
    for (int i = 0; i < porch; i++)
      doCycle(int'($urandom), int'($urandom), 1, 1, blankBit(0), 1);
    for (int i = 0; i < act; i++)
      doCycle(int'($urandom), int'($urandom), 1, 1, blankBit(1), 1);
    for (int i = 0; i < back; i++)
      doCycle(int'($urandom), int'($urandom), 1, 1, blankBit(0), 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog [%s] run incomplete got timeout exp completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1.25;
    cfgUseBlank = 1'b1; cfgInMode = 4'b0000;
    doReset();
    idle(4, 1);

    // R5 R6 R11: blank-aligned multiplexed lines, blank end jittered by 8/9
    tag = "R5";
    sendLine(2, 8, 7, 3, 1);
    sendLine(2, 9, 6, 3, 0);
    tag = "R11";
    sendLine(3, 8, 5, 4, 0);
    sendLine(2, 9, 1, 4, 0);
    sendLine(2, 8, 9, 2, 0);
    sendLine(2, 9, 4, 3, 0);
    idle(3, 1);

    // R7: parallel RGB, falling-edge byte must not matter
    cfgInMode = 4'b0111;
    doReset();
    tag = "R7";
    idle(2, 1);
    sendLine(2, 8, 4, 2, 1);
    sendLine(2, 9, 3, 2, 0);
    sendLine(2, 8, 1, 2, 0);
    idle(3, 1);

    // R10: offset window, blankN toggles randomly and must be ignored
    cfgInMode = 4'b0001; cfgUseBlank = 1'b0;
    cfgStartOffset = 10'd3; cfgActiveLen = 10'd5;
    doReset();
    tag = "R10";
    blankRandom = 1;
    for (int i = 0; i < 10; i++) doCycle(int'($urandom), int'($urandom), 1, 1, bit'($urandom % 2), 1);
    sendLine(2, 8, 6, 4, 1);
    sendLine(2, 8, 6, 4, 0);
    cfgStartOffset = 10'd0; cfgActiveLen = 10'd4;
    doReset();
    sendLine(2, 8, 6, 4, 1);
    sendLine(1, 8, 6, 4, 0);
    idle(3, 1);
    blankRandom = 0;

    // R3 R4: frame and line edges together, then line counter wrap
    cfgUseBlank = 1'b1; cfgInMode = 4'b0000;
    doReset();
    tag = "R3";
    sendLine(2, 2, 3, 1, 0);
    sendLine(2, 2, 3, 1, 1);
    tag = "R4";
    for (int i = 0; i < (1 << LINE_W) + 3; i++) sendLine(1, 1, 0, 0, 0);
    tag = "R3";
    sendLine(2, 2, 3, 1, 1);
    idle(3, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule